// File: doc/BRIEF.md
# Battery-check probe sequencer

This block sits on the host side of a battery-backed byte memory and runs a one-shot probe, normally once after power-up, to learn whether the backup cell kept its charge. A start pulse latches the probe address. The block then reads the byte at that address and writes its bitwise inverse back. It reads the same location a second time. If the second value is the inverse of the first, the write took effect and the battery is judged healthy. In that case the original byte is written back, so the memory ends up unchanged. If the inverse did not take effect, the block reports a low battery and issues no restore write. A low-battery result also means the stored data can no longer be trusted.

The memory side is a valid/ready request channel (read or write, address, write data) and a valid/ready read-response channel. The request fields stay stable while `req_valid_o` is high and `req_ready_i` is low, and they change only after a transfer. Only one request is ever outstanding. After a read is accepted, no new request is raised until its response has been taken. `rsp_ready_o` is high only while a read response is awaited, so the memory must hold `rsp_valid_i` and `rsp_data_i` until they are taken. Write requests receive no response. Completion is marked by a one-cycle `done_o` pulse. The two status outputs hold their values until the next accepted start.

Top module: `bprobe_seq`

## Requirements
- R1: After reset, `req_valid_o`, `rsp_ready_o`, `done_o`, `batt_ok_o` and `batt_low_o` are all 0.
- R2: A start pulse seen while idle latches `probe_addr_i`. The first request is then a read (`req_we_o`=0) at that address, and later changes of `probe_addr_i` have no effect on the probe.
- R3: The second request is a write (`req_we_o`=1) to the probe address whose data is the bitwise inverse of the first read's response.
- R4: The third request is a read of the probe address.
- R5: When the second response equals the inverse of the first, a fourth request writes the first response back to the probe address. The probe then ends with `batt_ok_o`=1 and `batt_low_o`=0, and the memory holds its original byte.
- R6: When the second response differs from that inverse, no fourth request is issued. The probe ends with `batt_low_o`=1 and `batt_ok_o`=0.
- R7: While `req_valid_o`=1 and `req_ready_i`=0, the request stays valid with unchanged `req_we_o`, `req_addr_o` and `req_wdata_o`. No request is raised while a read response is awaited.
- R8: Each probe gives exactly one `done_o` pulse, one cycle wide, and the status outputs are never both 1.
- R9: The status outputs change only at the `done_o` cycle, when set, or in the cycle after an accepted start, when both clear. Otherwise they hold.
- R10: A start pulse during a running probe, including in its `done_o` cycle, is ignored. It causes no extra requests, no second `done_o` and no status change.
- R11: `rsp_ready_o` is 1 only from the cycle after a read request is accepted until that read's response transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Probe start pulse, honoured only when idle |
| probe_addr_i | input | ADDR_W | Location to probe, latched on start |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Memory accepts the request |
| req_we_o | output | 1 | 1 = write, 0 = read |
| req_addr_o | output | ADDR_W | Request address |
| req_wdata_o | output | DATA_W | Write data |
| rsp_valid_i | input | 1 | Read response valid |
| rsp_ready_o | output | 1 | Read response can be taken |
| rsp_data_i | input | DATA_W | Read response data |
| done_o | output | 1 | One-cycle end-of-probe pulse |
| batt_ok_o | output | 1 | Inverse write took effect, memory restored |
| batt_low_o | output | 1 | Inverse write lost, stored data suspect |

## Verification
Two events can fall in the same cycle: a new start pulse and the end of a running probe (its `done_o` cycle), or a start and an outstanding read response. The bench raises start while the probe is mid-flight, with the address input changed, and again exactly in the cycle `done_o` is high. It then judges that the request log still holds only the expected three or four operations, that one `done_o` was counted, and that the status stays put for the following cycles. Back-pressure is provoked with random ready stalls and slow responses, and request stability is judged on every stalled cycle.

// File: rtl/bprobe_pkg.sv
`timescale 1ns/1ps
package bprobe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ1, ST_WCOMP, ST_READ2, ST_CMP, ST_RESTORE, ST_DONE
  } probe_st_e;

  typedef enum logic [1:0] {
    PH_IDLE, PH_REQ, PH_WAIT
  } port_ph_e;
endpackage

// File: rtl/bprobe_port.sv
`timescale 1ns/1ps
module bprobe_port
  import bprobe_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              go_we_i,
  input  logic [ADDR_W-1:0] go_addr_i,
  input  logic [DATA_W-1:0] go_wdata_i,
  output logic              fin_o,
  output logic [DATA_W-1:0] fin_data_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic              req_we_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_wdata_o,
  input  logic              rsp_valid_i,
  output logic              rsp_ready_o,
  input  logic [DATA_W-1:0] rsp_data_i
);
  port_ph_e          ph_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              fin_q;
  logic [DATA_W-1:0] fdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      fin_q   <= 1'b0;
      fdata_q <= '0;
    end else begin
      fin_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: begin
          if (go_i) begin
            ph_q    <= PH_REQ;
            we_q    <= go_we_i;
            addr_q  <= go_addr_i;
            wdata_q <= go_wdata_i;
          end
        end
        PH_REQ: begin
          if (req_ready_i) begin
            if (we_q) begin
              ph_q  <= PH_IDLE;
              fin_q <= 1'b1;
            end else begin
              ph_q <= PH_WAIT;
            end
          end
        end
        PH_WAIT: begin
          if (rsp_valid_i) begin
            ph_q    <= PH_IDLE;
            fin_q   <= 1'b1;
            fdata_q <= rsp_data_i;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign req_valid_o = (ph_q == PH_REQ);
  assign rsp_ready_o = (ph_q == PH_WAIT);
  assign req_we_o    = we_q;
  assign req_addr_o  = addr_q;
  assign req_wdata_o = wdata_q;
  assign fin_o       = fin_q;
  assign fin_data_o  = fdata_q;
endmodule

// File: rtl/bprobe_data.sv
`timescale 1ns/1ps
module bprobe_data #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap1_i,
  input  logic              cap2_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] orig_o,
  output logic [DATA_W-1:0] inv_o,
  output logic              match_o
);
  logic [DATA_W-1:0] first_q;
  logic [DATA_W-1:0] second_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q  <= '0;
      second_q <= '0;
    end else begin
      if (cap1_i) first_q  <= din_i;
      if (cap2_i) second_q <= din_i;
    end
  end

  assign orig_o  = first_q;
  assign inv_o   = ~first_q;
  assign match_o = (second_q == ~first_q);
endmodule

// File: rtl/bprobe_fsm.sv
`timescale 1ns/1ps
module bprobe_fsm
  import bprobe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic fin_i,
  input  logic match_i,
  output logic accept_o,
  output logic go_o,
  output logic go_we_o,
  output logic wsel_inv_o,
  output logic cap1_o,
  output logic cap2_o,
  output logic done_o,
  output logic ok_o,
  output logic low_o
);
  probe_st_e st_q, st_d;
  logic      sent_q;
  logic      ok_q, low_q;
  logic      set_ok, set_low;

  always_comb begin
    st_d       = st_q;
    accept_o   = 1'b0;
    go_o       = 1'b0;
    go_we_o    = 1'b0;
    wsel_inv_o = 1'b0;
    cap1_o     = 1'b0;
    cap2_o     = 1'b0;
    set_ok     = 1'b0;
    set_low    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          accept_o = 1'b1;
          st_d     = ST_READ1;
        end
      end
      ST_READ1: begin
        go_o = !sent_q;
        if (fin_i) begin
          cap1_o = 1'b1;
          st_d   = ST_WCOMP;
        end
      end
      ST_WCOMP: begin
        go_o       = !sent_q;
        go_we_o    = 1'b1;
        wsel_inv_o = 1'b1;
        if (fin_i) st_d = ST_READ2;
      end
      ST_READ2: begin
        go_o = !sent_q;
        if (fin_i) begin
          cap2_o = 1'b1;
          st_d   = ST_CMP;
        end
      end
      ST_CMP: begin
        if (match_i) begin
          st_d = ST_RESTORE;
        end else begin
          set_low = 1'b1;
          st_d    = ST_DONE;
        end
      end
      ST_RESTORE: begin
        go_o    = !sent_q;
        go_we_o = 1'b1;
        if (fin_i) begin
          set_ok = 1'b1;
          st_d   = ST_DONE;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sent_q <= 1'b0;
      ok_q   <= 1'b0;
      low_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_d != st_q) sent_q <= 1'b0;
      else if (go_o)    sent_q <= 1'b1;
      if (accept_o) begin
        ok_q  <= 1'b0;
        low_q <= 1'b0;
      end
      if (set_ok)  ok_q  <= 1'b1;
      if (set_low) low_q <= 1'b1;
    end
  end

  assign done_o = (st_q == ST_DONE);
  assign ok_o   = ok_q;
  assign low_o  = low_q;
endmodule

// File: rtl/bprobe_seq.sv
`timescale 1ns/1ps
module bprobe_seq #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] probe_addr_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic              req_we_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_wdata_o,
  input  logic              rsp_valid_i,
  output logic              rsp_ready_o,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              done_o,
  output logic              batt_ok_o,
  output logic              batt_low_o
);
  logic              accept, go, go_we, wsel_inv, cap1, cap2, fin, match;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] fin_data, orig, inv, go_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n)      addr_q <= '0;
    else if (accept) addr_q <= probe_addr_i;
  end

  assign go_wdata = wsel_inv ? inv : orig;

  bprobe_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .fin_i      (fin),
    .match_i    (match),
    .accept_o   (accept),
    .go_o       (go),
    .go_we_o    (go_we),
    .wsel_inv_o (wsel_inv),
    .cap1_o     (cap1),
    .cap2_o     (cap2),
    .done_o     (done_o),
    .ok_o       (batt_ok_o),
    .low_o      (batt_low_o)
  );

  bprobe_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_i        (go),
    .go_we_i     (go_we),
    .go_addr_i   (addr_q),
    .go_wdata_i  (go_wdata),
    .fin_o       (fin),
    .fin_data_o  (fin_data),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_we_o    (req_we_o),
    .req_addr_o  (req_addr_o),
    .req_wdata_o (req_wdata_o),
    .rsp_valid_i (rsp_valid_i),
    .rsp_ready_o (rsp_ready_o),
    .rsp_data_i  (rsp_data_i)
  );

  bprobe_data #(.DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap1_i  (cap1),
    .cap2_i  (cap2),
    .din_i   (fin_data),
    .orig_o  (orig),
    .inv_o   (inv),
    .match_o (match)
  );
endmodule

// File: rtl/bprobe_seq_chk.sv
`timescale 1ns/1ps
module bprobe_seq_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic              req_we_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [DATA_W-1:0] req_wdata_o,
  input logic              rsp_ready_o,
  input logic              done_o,
  input logic              batt_ok_o,
  input logic              batt_low_o
);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_we_o)
      && $stable(req_addr_o) && $stable(req_wdata_o)));

  // R7
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready_o |-> !req_valid_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(batt_ok_o && batt_low_o));

  // R9
  status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(batt_ok_o) || $rose(batt_low_o)) |-> done_o);

  // R9
  status_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(batt_ok_o) || $fell(batt_low_o)) |-> $past(start_i));

  // R11
  rsp_ready_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_ready_o) |-> $past(req_valid_o && req_ready_i && !req_we_o));
endmodule

bind bprobe_seq bprobe_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_we_o    (req_we_o),
  .req_addr_o  (req_addr_o),
  .req_wdata_o (req_wdata_o),
  .rsp_ready_o (rsp_ready_o),
  .done_o      (done_o),
  .batt_ok_o   (batt_ok_o),
  .batt_low_o  (batt_low_o)
);

// File: tb/bprobe_seq_bench.sv
`timescale 1ns/1ps
module bprobe_seq_bench;
  localparam int AW = 11;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] probe_addr_i = '0;
  logic          req_valid_o, req_we_o, rsp_ready_o, done_o, batt_ok_o, batt_low_o;
  logic [AW-1:0] req_addr_o;
  logic [DW-1:0] req_wdata_o;
  logic          req_ready_i = 1'b0;
  logic          rsp_valid_i = 1'b0;
  logic [DW-1:0] rsp_data_i = '0;

  always #2.5 clk = ~clk;

  bprobe_seq #(.ADDR_W(AW), .DATA_W(DW)) u_bprobe_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .probe_addr_i(probe_addr_i),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_we_o(req_we_o),
    .req_addr_o(req_addr_o), .req_wdata_o(req_wdata_o), .rsp_valid_i(rsp_valid_i),
    .rsp_ready_o(rsp_ready_o), .rsp_data_i(rsp_data_i), .done_o(done_o),
    .batt_ok_o(batt_ok_o), .batt_low_o(batt_low_o));

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  task automatic chk(input bit cond, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model state
  logic [DW-1:0] mem [0:(1<<AW)-1];
  bit            blk_first = 0;
  bit            stall_en = 0;
  int            lat_cfg = 0;
  bit            pending = 0, drop_rsp = 0;
  int            lat_cnt = 0;
  logic [DW-1:0] pdata;
  bit            op_we[$];
  int            op_addr[$];
  int            op_data[$];
  int            done_cnt = 0;
  bit            prev_done = 0;
  bit            prev_stall = 0;
  bit            p_we;
  int            p_addr, p_data;

  // Reference memory and per-clock monitor, evaluated away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        // R7: stalled request must stay unchanged
        chk(req_valid_o && req_we_o == p_we && int'(req_addr_o) == p_addr
            && int'(req_wdata_o) == p_data, "R7", "stalled request held",
            int'(req_addr_o), p_addr);
      end
      if (drop_rsp) begin
        rsp_valid_i = 1'b0;
        pending = 0;
        drop_rsp = 0;
      end
      if (rsp_ready_o) begin
        // R11 / R7: response ready only with an outstanding read, no request meanwhile
        chk(pending && !req_valid_o, "R11", "rsp_ready only while read pending",
            int'(rsp_ready_o), int'(pending));
      end
      if (pending && !rsp_valid_i) begin
        if (lat_cnt == 0) begin
          rsp_valid_i = 1'b1;
          rsp_data_i = pdata;
        end else lat_cnt--;
      end
      if (rsp_valid_i && rsp_ready_o) drop_rsp = 1;
      req_ready_i = stall_en ? ($urandom_range(0, 2) == 0) : 1'b1;
      if (req_valid_o && req_ready_i) begin
        op_we.push_back(req_we_o);
        op_addr.push_back(int'(req_addr_o));
        if (req_we_o) begin
          op_data.push_back(int'(req_wdata_o));
          if (blk_first) blk_first = 0;
          else mem[req_addr_o] = req_wdata_o;
        end else begin
          op_data.push_back(int'(mem[req_addr_o]));
          pending = 1;
          pdata = mem[req_addr_o];
          lat_cnt = stall_en ? $urandom_range(0, lat_cfg) : lat_cfg;
        end
      end
      prev_stall = req_valid_o && !req_ready_i;
      p_we = req_we_o; p_addr = int'(req_addr_o); p_data = int'(req_wdata_o);
      if (done_o) begin
        done_cnt++;
        // R8: done lasts one cycle, status exclusive
        chk(!prev_done && !(batt_ok_o && batt_low_o), "R8", "done pulse / status",
            {batt_ok_o, batt_low_o}, 0);
      end
      prev_done = done_o;
    end
  end

  task automatic run_probe(input int addr, input logic [DW-1:0] init, input bit block,
                           input bit stall, input int lat, input bit inject);
    bit got = 0;
    bit inj_done = 0;
    int d0;
    int nops;
    logic [DW-1:0] second;
    mem[addr] = init;
    blk_first = block;
    stall_en = stall;
    lat_cfg = lat;
    op_we.delete(); op_addr.delete(); op_data.delete();
    d0 = done_cnt;
    @(negedge clk);
    start_i = 1'b1;
    probe_addr_i = AW'(addr);
    @(negedge clk);
    start_i = 1'b0;
    // R9: accepted start clears status
    chk(!batt_ok_o && !batt_low_o, "R9", "status cleared on start",
        {batt_ok_o, batt_low_o}, 0);
    for (int i = 0; i < 3000 && !got; i++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (done_o) begin
        got = 1;
        if (inject) start_i = 1'b1;
      end else if (inject && !inj_done && op_we.size() == 2) begin
        start_i = 1'b1;
        inj_done = 1;
        probe_addr_i = ~AW'(addr);
      end
    end
    @(negedge clk);
    start_i = 1'b0;
    chk(got, "R8", "done seen", int'(got), 1);
    nops = block ? 3 : 4;
    second = block ? init : ~init;
    chk(op_we.size() == nops, block ? "R6" : "R5", "request count", op_we.size(), nops);
    if (op_we.size() >= 3) begin
      // R2
      chk(!op_we[0] && op_addr[0] == addr && op_data[0] == int'(init), "R2",
          "first read", op_addr[0], addr);
      // R3
      chk(op_we[1] && op_addr[1] == addr && op_data[1] == int'(DW'(~init)), "R3",
          "inverse write", op_data[1], int'(DW'(~init)));
      // R4
      chk(!op_we[2] && op_addr[2] == addr && op_data[2] == int'(second), "R4",
          "second read", op_data[2], int'(second));
    end
    if (!block && op_we.size() == 4) begin
      // R5
      chk(op_we[3] && op_addr[3] == addr && op_data[3] == int'(init), "R5",
          "restore write", op_data[3], int'(init));
    end
    if (block) begin
      chk(batt_low_o && !batt_ok_o, "R6", "low status", {batt_ok_o, batt_low_o}, 1);
    end else begin
      chk(batt_ok_o && !batt_low_o, "R5", "ok status", {batt_ok_o, batt_low_o}, 2);
    end
    chk(mem[addr] == init, block ? "R6" : "R5", "memory content", int'(mem[addr]),
        int'(init));
    chk(done_cnt == d0 + 1, "R8", "one done per probe", done_cnt - d0, 1);
    if (inject) begin
      for (int i = 0; i < 10; i++) @(negedge clk);
      // R10: ignored starts cause no traffic, no done, no status change
      chk(op_we.size() == nops && done_cnt == d0 + 1, "R10", "busy start ignored",
          op_we.size(), nops);
      chk(block ? batt_low_o : batt_ok_o, "R10", "status kept after ignored start",
          {batt_ok_o, batt_low_o}, block ? 1 : 2);
    end
  endtask

  initial begin
    #500000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(i * 7 + 3);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!req_valid_o && !rsp_ready_o && !done_o && !batt_ok_o && !batt_low_o, "R1",
        "reset outputs", {req_valid_o, rsp_ready_o, done_o, batt_ok_o, batt_low_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_valid_o && !done_o, "R1", "idle after reset", int'(req_valid_o), 0);

    run_probe(12'h123, 8'h5A, 0, 0, 0, 0);
    // R9: status held while idle
    for (int i = 0; i < 20; i++) @(negedge clk);
    chk(batt_ok_o && !batt_low_o, "R9", "status held", {batt_ok_o, batt_low_o}, 2);

    run_probe(11'h7FF, 8'h00, 1, 1, 3, 0);
    for (int i = 0; i < 20; i++) @(negedge clk);
    chk(batt_low_o && !batt_ok_o, "R9", "low status held", {batt_ok_o, batt_low_o}, 1);

    run_probe(0, 8'hFF, 0, 1, 3, 1);
    run_probe(11'h2A5, 8'hC3, 1, 0, 1, 1);
    run_probe(11'h400, 8'h81, 0, 1, 2, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule